// File: doc/BRIEF.md
# Thread Interrupt Presenter

This block is the interrupt presentation stage for one hardware thread. An event router upstream sends priority notifications, one per cycle at most. The block keeps one pending bit per priority level. It works out the most favoured pending priority, where a lower number means more urgent. It compares that priority with the thread's current priority threshold and drives an exception line to the thread whenever a pending priority beats the threshold.

Software reaches the block through a simple load/store port with byte addresses. A physical-ring byte window exposes the notification source, the threshold, the pending bits and the most favoured pending priority. A special acknowledge load returns the source type and the acknowledged priority in one 16-bit word. The same load moves the threshold to that priority and retires its pending bit, all in one step.

A pool ring holds a setup word and a context word. The context word carries a valid flag and the CAM value of the virtual processor. A pull load reads the context word and invalidates it. The guest ring is only a stub: writes to it are dropped and loads from it return zero. Each thread programs its own threshold. A threshold of 0xFF lets every priority through.

Top module: `thread_irq_presenter`

## Requirements
- R1: After reset the pending bits are clear, the threshold reads 0x00, both pool words read zero, the exception line is low and no read data is valid.
- R2: A notification at priority p sets pending bit p. Bits accumulate across notifications. The pending byte is read at address 0x032, with bit p standing for priority p.
- R3: The pending priority read at 0x037 equals the index of the lowest-numbered set pending bit, or 0xFF when no bit is set.
- R4: The exception line is high exactly when the pending priority is numerically below the threshold. While it is high, the source byte at 0x030 reads 0x80 (type 2, physical, in bits 7:6); otherwise it reads 0x00.
- R5: A store to 0x031 loads the threshold from wdata[7:0], and the threshold reads back at 0x031. A threshold of 0xFF admits every priority.
- R6: A load at 0x800 while the exception line is high returns 0x80 in bits 15:8 (source type 2 in bits 15:14) and the acknowledged priority in bits 7:0. It sets the threshold to that priority and clears that pending bit.
- R7: A load at 0x800 while the exception line is low returns source type 0 with the current threshold in bits 7:0, and it changes no state.
- R8: When a notification arrives in the same cycle as an acknowledge of the same priority, that pending bit stays set.
- R9: A store to 0x020 writes the pool setup word, read back whole. A store to 0x028 writes the context word: bit 31 is the valid flag and bits CAM_W-1:0 hold the CAM value. The other bits of the context word read as zero.
- R10: A load at 0x828 returns the context word as it stood before the load, then clears its valid bit and keeps the CAM value.
- R11: Stores to the guest ring (0x010–0x017) and to unmapped addresses have no effect, and loads from them return zero.
- R12: Every load returns its data with the read-valid strobe exactly one cycle after the request. Stores never raise the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| notify_valid | input | 1 | Priority notification strobe from the event router |
| notify_prio | input | PRIO_W | Priority of the notification |
| mmio_valid | input | 1 | Load/store request |
| mmio_write | input | 1 | 1 for store, 0 for load |
| mmio_addr | input | ADDR_W | Byte address |
| mmio_wdata | input | 32 | Store data |
| mmio_rvalid | output | 1 | Load data valid, one cycle after the request |
| mmio_rdata | output | 32 | Load data |
| irq_o | output | 1 | Exception line to the thread |

## Verification
A corrupted pending bit or threshold shows up on the exception line in the same cycle, because that line is derived combinationally from state. A wrong value also comes back in the very next load of the source, pending or priority bytes. A mistake on the acknowledge path appears in three places: the returned word, the threshold read-back, and the exception line one cycle after the acknowledge. A pull that fails to invalidate the context is caught by the next load of the context word.

// File: rtl/tip_pkg.sv
package tip_pkg;

   localparam int unsigned DATA_W = 32;

   // physical ring byte addresses
   localparam int unsigned A_SRC     = 'h030;
   localparam int unsigned A_THRESH  = 'h031;
   localparam int unsigned A_PEND    = 'h032;
   localparam int unsigned A_BEST    = 'h037;
   // pool ring words
   localparam int unsigned A_POOL_W0 = 'h020;
   localparam int unsigned A_POOL_W2 = 'h028;
   // special loads
   localparam int unsigned A_ACK     = 'h800;
   localparam int unsigned A_PULL    = 'h828;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_POOL = 2'd1,
      SRC_PHYS = 2'd2,
      SRC_LSI  = 2'd3
   } src_type_e;

   typedef struct packed {
      logic src;
      logic thresh;
      logic pend;
      logic best;
      logic pool_w0;
      logic pool_w2;
      logic ack;
      logic pull;
   } tip_dec_t;

endpackage

// File: rtl/tip_addr_decode.sv
module tip_addr_decode
   import tip_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output tip_dec_t          dec
);

   if (ADDR_W < 12) begin : g_bad_addr_w
      $error("tip_addr_decode: ADDR_W must reach 0x828");
   end

   always_comb begin
      dec         = '0;
      dec.src     = (addr == ADDR_W'(A_SRC));
      dec.thresh  = (addr == ADDR_W'(A_THRESH));
      dec.pend    = (addr == ADDR_W'(A_PEND));
      dec.best    = (addr == ADDR_W'(A_BEST));
      dec.pool_w0 = (addr == ADDR_W'(A_POOL_W0));
      dec.pool_w2 = (addr == ADDR_W'(A_POOL_W2));
      dec.ack     = (addr == ADDR_W'(A_ACK));
      dec.pull    = (addr == ADDR_W'(A_PULL));
   end

endmodule

// File: rtl/tip_pending_buf.sv
module tip_pending_buf #(
   parameter int NUM_PRIO = 8,
   localparam int PRIO_W  = $clog2(NUM_PRIO)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_v,
   input  logic [PRIO_W-1:0]   set_idx,
   input  logic                clr_v,
   input  logic [PRIO_W-1:0]   clr_idx,
   output logic [NUM_PRIO-1:0] pend_o
);

   logic [NUM_PRIO-1:0] pend_q;
   logic [NUM_PRIO-1:0] set_mask;
   logic [NUM_PRIO-1:0] clr_mask;

   assign set_mask = set_v ? (NUM_PRIO'(1) << set_idx) : '0;
   assign clr_mask = clr_v ? (NUM_PRIO'(1) << clr_idx) : '0;

   // a new notification wins over a retire of the same level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_mask) | set_mask;
   end

   assign pend_o = pend_q;

   // R2
   notify_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_v |=> pend_q[$past(set_idx)]);

   // R8
   retire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v && !(set_v && set_idx == clr_idx)) |=> !pend_q[$past(clr_idx)]);

endmodule

// File: rtl/tip_prio_find.sv
module tip_prio_find #(
   parameter int NUM_PRIO = 8,
   localparam int PRIO_W  = $clog2(NUM_PRIO)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PRIO-1:0] pend,
   output logic                found_o,
   output logic [PRIO_W-1:0]   idx_o
);

   logic [NUM_PRIO:0]   below;
   logic [NUM_PRIO-1:0] first;

   assign below[0] = 1'b0;

   for (genvar i = 0; i < NUM_PRIO; i++) begin : g_bit
      assign first[i]   = pend[i] & ~below[i];
      assign below[i+1] = below[i] | pend[i];
   end

   assign found_o = below[NUM_PRIO];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < NUM_PRIO; i++) begin
         if (first[i]) idx_o = idx_o | PRIO_W'(i);
      end
   end

   // R3
   first_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(first));

   // R3
   lowest_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      found_o |-> (pend[idx_o] &&
                   ((pend & ((NUM_PRIO'(1) << idx_o) - NUM_PRIO'(1))) == '0)));

endmodule

// File: rtl/tip_pool_ctx.sv
module tip_pool_ctx #(
   parameter int CAM_W = 24
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        w0_we,
   input  logic        w2_we,
   input  logic        pull,
   input  logic [31:0] wdata,
   output logic [31:0] word0_o,
   output logic [31:0] word2_o
);

   if (CAM_W < 1 || CAM_W > 31) begin : g_bad_cam_w
      $error("tip_pool_ctx: CAM_W must lie in 1..31");
   end

   localparam int PAD_W = 31 - CAM_W;

   logic [31:0]      word0_q;
   logic             vld_q;
   logic [CAM_W-1:0] cam_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word0_q <= '0;
         vld_q   <= 1'b0;
         cam_q   <= '0;
      end else begin
         if (w0_we) word0_q <= wdata;
         if (w2_we) begin
            vld_q <= wdata[31];
            cam_q <= wdata[CAM_W-1:0];
         end else if (pull) begin
            vld_q <= 1'b0;
         end
      end
   end

   assign word0_o = word0_q;

   if (PAD_W > 0) begin : g_pad
      assign word2_o = {vld_q, {PAD_W{1'b0}}, cam_q};
   end else begin : g_nopad
      assign word2_o = {vld_q, cam_q};
   end

   // R10
   pull_invalidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pull && !w2_we) |=> !word2_o[31]);

   // R10
   pull_keeps_cam_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pull && !w2_we) |=> $stable(cam_q));

endmodule

// File: rtl/thread_irq_presenter.sv
module thread_irq_presenter
   import tip_pkg::*;
#(
   parameter int NUM_PRIO = 8,
   parameter int CAM_W    = 24,
   parameter int ADDR_W   = 12,
   localparam int PRIO_W  = $clog2(NUM_PRIO)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              notify_valid,
   input  logic [PRIO_W-1:0] notify_prio,
   input  logic              mmio_valid,
   input  logic              mmio_write,
   input  logic [ADDR_W-1:0] mmio_addr,
   input  logic [31:0]       mmio_wdata,
   output logic              mmio_rvalid,
   output logic [31:0]       mmio_rdata,
   output logic              irq_o
);

   if (NUM_PRIO < 2 || NUM_PRIO > 8) begin : g_bad_prio
      $error("thread_irq_presenter: NUM_PRIO must lie in 2..8");
   end

   tip_dec_t            dec;
   logic                rd_req;
   logic                wr_req;
   logic                ack_hit;
   logic                pull_hit;
   logic [NUM_PRIO-1:0] pend;
   logic                found;
   logic [PRIO_W-1:0]   best_idx;
   logic [7:0]          best;
   logic [7:0]          thresh_q;
   logic [7:0]          src_byte;
   logic [31:0]         pool_w0;
   logic [31:0]         pool_w2;
   logic [31:0]         rd_mux;
   logic                rvalid_q;
   logic [31:0]         rdata_q;

   tip_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (mmio_addr),
      .dec  (dec)
   );

   assign rd_req   = mmio_valid & ~mmio_write;
   assign wr_req   = mmio_valid &  mmio_write;
   assign ack_hit  = rd_req & dec.ack;
   assign pull_hit = rd_req & dec.pull;

   tip_pending_buf #(.NUM_PRIO(NUM_PRIO)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_v   (notify_valid),
      .set_idx (notify_prio),
      .clr_v   (ack_hit & irq_o),
      .clr_idx (best_idx),
      .pend_o  (pend)
   );

   tip_prio_find #(.NUM_PRIO(NUM_PRIO)) u_find (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend    (pend),
      .found_o (found),
      .idx_o   (best_idx)
   );

   tip_pool_ctx #(.CAM_W(CAM_W)) u_pool (
      .clk     (clk),
      .rst_n   (rst_n),
      .w0_we   (wr_req & dec.pool_w0),
      .w2_we   (wr_req & dec.pool_w2),
      .pull    (pull_hit),
      .wdata   (mmio_wdata),
      .word0_o (pool_w0),
      .word2_o (pool_w2)
   );

   assign best     = found ? 8'(best_idx) : 8'hFF;
   assign irq_o    = found && (best < thresh_q);
   assign src_byte = irq_o ? {SRC_PHYS, 6'b0} : {SRC_NONE, 6'b0};

   // threshold: software store, or moved to the taken priority on acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 thresh_q <= 8'h00;
      else if (ack_hit && irq_o)  thresh_q <= best;
      else if (wr_req && dec.thresh) thresh_q <= mmio_wdata[7:0];
   end

   always_comb begin
      rd_mux = '0;
      if (dec.src)          rd_mux = {24'b0, src_byte};
      else if (dec.thresh)  rd_mux = {24'b0, thresh_q};
      else if (dec.pend)    rd_mux = 32'(pend);
      else if (dec.best)    rd_mux = {24'b0, best};
      else if (dec.pool_w0) rd_mux = pool_w0;
      else if (dec.pool_w2) rd_mux = pool_w2;
      else if (dec.pull)    rd_mux = pool_w2;
      else if (dec.ack)     rd_mux = {16'b0, src_byte, (irq_o ? best : thresh_q)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= rd_req;
         if (rd_req) rdata_q <= rd_mux;
      end
   end

   assign mmio_rvalid = rvalid_q;
   assign mmio_rdata  = rdata_q;

   // R6
   ack_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && irq_o) |=> (thresh_q == $past(best)));

   // R6
   ack_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && irq_o) |=> (mmio_rdata[15:14] == SRC_PHYS));

   // R7
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !irq_o && !notify_valid) |=> ($stable(thresh_q) && $stable(pend)));

   // R4
   irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (pend != '0));

   // R12
   rvalid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> mmio_rvalid);

   // R12
   rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !mmio_rvalid);

endmodule

// File: tb/thread_irq_presenter_test.sv
`timescale 1ns/1ps
module thread_irq_presenter_test;

   localparam int NP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        notify_valid = 1'b0;
   logic [2:0]  notify_prio = '0;
   logic        mmio_valid = 1'b0;
   logic        mmio_write = 1'b0;
   logic [11:0] mmio_addr = '0;
   logic [31:0] mmio_wdata = '0;
   logic        mmio_rvalid;
   logic [31:0] mmio_rdata;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   thread_irq_presenter uut (
      .clk(clk), .rst_n(rst_n),
      .notify_valid(notify_valid), .notify_prio(notify_prio),
      .mmio_valid(mmio_valid), .mmio_write(mmio_write),
      .mmio_addr(mmio_addr), .mmio_wdata(mmio_wdata),
      .mmio_rvalid(mmio_rvalid), .mmio_rdata(mmio_rdata),
      .irq_o(irq_o)
   );

   // behavioural reference state
   int          m_pend;
   int          m_thr;
   logic [31:0] m_w0;
   logic [31:0] m_w2;
   bit          e_rv;
   logic [31:0] e_rd;
   string       e_tag;
   string       cur_tag = "R1";

   function automatic int best_of(input int pend);
      for (int i = 0; i < NP; i++) if (pend[i]) return i;
      return 255;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      int  b;
      bit  hot;
      if (!rst_n) begin
         m_pend = 0; m_thr = 0; m_w0 = '0; m_w2 = '0; e_rv = 0; e_rd = '0; e_tag = "R1";
      end else begin
         b   = best_of(m_pend);
         hot = (b < m_thr);
         e_rv = 0;
         if (mmio_valid && !mmio_write) begin
            e_rv  = 1;
            e_tag = cur_tag;
            case (mmio_addr)
               12'h030: e_rd = hot ? 32'h80 : 32'h0;
               12'h031: e_rd = 32'(m_thr);
               12'h032: e_rd = 32'(m_pend);
               12'h037: e_rd = 32'(b);
               12'h020: e_rd = m_w0;
               12'h028: e_rd = m_w2;
               12'h800: begin
                  if (hot) begin
                     e_rd   = 32'h8000 | 32'(b);
                     m_thr  = b;
                     m_pend = m_pend & ~(1 << b);
                  end else begin
                     e_rd = 32'(m_thr);
                  end
               end
               12'h828: begin
                  e_rd     = m_w2;
                  m_w2[31] = 1'b0;
               end
               default: e_rd = '0;
            endcase
         end
         if (mmio_valid && mmio_write) begin
            case (mmio_addr)
               12'h031: m_thr = int'(mmio_wdata[7:0]);
               12'h020: m_w0  = mmio_wdata;
               12'h028: m_w2  = mmio_wdata & 32'h80FF_FFFF;
               default: ;
            endcase
         end
         if (notify_valid) m_pend = m_pend | (1 << notify_prio);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check("R4 irq", 32'(irq_o), 32'(best_of(m_pend) < m_thr));
         check("R12 rvalid", 32'(mmio_rvalid), 32'(e_rv));
         if (e_rv) check(e_tag, mmio_rdata, e_rd);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         failures++;
         $display("FAIL R12 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic step(input bit nv, input int np, input bit bv, input bit we,
                       input int addr, input logic [31:0] wd, input string tag);
      @(posedge clk);
      #1;
      notify_valid = nv;
      notify_prio  = 3'(np);
      mmio_valid   = bv;
      mmio_write   = we;
      mmio_addr    = 12'(addr);
      mmio_wdata   = wd;
      cur_tag      = tag;
   endtask

   task automatic rd(input int addr, input string tag);
      step(0, 0, 1, 0, addr, '0, tag);
   endtask

   task automatic wr(input int addr, input logic [31:0] wd);
      step(0, 0, 1, 1, addr, wd, "R12");
   endtask

   task automatic note(input int p);
      step(1, p, 0, 0, 0, '0, "R2");
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, '0, "R12");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 irq in reset", 32'(irq_o), 32'h0);
      check("R1 rvalid in reset", 32'(mmio_rvalid), 32'h0);
      rst_n = 1'b1;

      // reset contents
      rd('h030, "R1 src");
      rd('h031, "R1 thresh");
      rd('h032, "R1 pend");
      rd('h037, "R3 best empty");
      rd('h020, "R1 pool w0");
      rd('h028, "R1 pool w2");

      // notification held off by threshold 0
      note(5);
      rd('h032, "R2 pend one");
      rd('h037, "R3 best 5");
      rd('h030, "R4 src blocked");

      // open threshold
      wr('h031, 32'hFF);
      rd('h031, "R5 thresh ff");
      rd('h030, "R4 src hot");
      note(2);
      note(6);
      rd('h032, "R2 pend accum");
      rd('h037, "R3 best 2");

      // acknowledge and idle acknowledge
      rd('h800, "R6 ack 2");
      rd('h031, "R6 thresh moved");
      rd('h032, "R6 pend cleared");
      rd('h800, "R7 ack none");
      rd('h031, "R7 thresh kept");

      wr('h031, 32'hFF);
      rd('h800, "R6 ack 5");
      wr('h031, 32'hFF);
      // collision: acknowledge of 6 with a new level-6 notification
      step(1, 6, 1, 0, 'h800, '0, "R8 ack 6");
      rd('h032, "R8 pend kept");
      rd('h031, "R8 thresh 6");

      // guest ring and unmapped addresses
      wr('h011, 32'h00);
      wr('h7F0, 32'h1234);
      rd('h011, "R11 guest read");
      rd('h031, "R11 thresh kept");
      rd('h7F0, "R11 unmapped read");
      rd('h033, "R11 reserved byte");

      // pool ring
      wr('h020, 32'hFF);
      rd('h020, "R9 pool w0");
      wr('h028, 32'h7F12_3456);
      rd('h028, "R9 pool w2 masked");
      wr('h028, 32'h8012_3456);
      rd('h028, "R9 pool w2 valid");
      rd('h828, "R10 pull");
      rd('h028, "R10 after pull");
      rd('h828, "R10 pull again");

      // drain all levels one by one
      idle();
      wr('h031, 32'hFF);
      for (int p = NP - 1; p >= 0; p--) note(p);
      rd('h032, "R2 pend full");
      for (int i = 0; i <= NP; i++) begin
         wr('h031, 32'hFF);
         rd('h800, "R6 drain ack");
         rd('h037, "R3 drain best");
      end
      rd('h800, "R7 drain done");

      // back-to-back loads with notifications
      wr('h031, 32'h04);
      step(1, 3, 1, 0, 'h030, '0, "R4 src pre");
      step(1, 4, 1, 0, 'h030, '0, "R4 src post");
      step(0, 0, 1, 0, 'h800, '0, "R6 ack 3");
      step(0, 0, 1, 0, 'h800, '0, "R7 ack 4 blocked");
      idle();
      idle();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule